// File: doc/BRIEF.md
# ALU Status Flags and Branch Condition Unit

This block is the arithmetic and status slice of a small processor datapath. It takes two operands and a two-bit operation code, forms an addition, a subtraction, a compare or a bit test, and derives four status flags (carry, sign, zero, overflow) from the internal adder carries and the result bits. Compare and test exist only to set the flags. Their result is thrown away, and the result register keeps its earlier value.

The flags sit in a register that loads only on a cycle where the flag-enable input is high. A five-bit condition code is evaluated at any time against the stored flags and drives a take-branch output. The evaluator covers the single-flag tests and the full set of unsigned and signed relational tests that follow an A minus B compare. The program counter update and the instruction decoding belong to the neighbouring blocks.

Top module: `alu_cond_unit`

## Requirements
- R1: With opSel=00 (add) and flagEn high, the next clock loads result with (opA+opB) mod 2^W and sets the carry flag to the carry out of the top adder bit. resultValid is high for exactly that following cycle.
- R2: After any flag load, the sign flag equals bit W-1 of the value the operation formed (the sum, difference or AND).
- R3: After any flag load, the zero flag is 1 exactly when all W bits of the formed value are zero.
- R4: For add, subtract and compare, the overflow flag equals the carry into the top bit XOR the carry out of the top bit. It is set exactly when the signed result does not fit in W bits.
- R5: Subtract (opSel=01) and compare (opSel=10) form opA + ~opB + 1. The carry flag is 1 when there is no borrow (opA >= opB unsigned), and subtract writes the difference to result.
- R6: Compare and test (opSel=11) update only the flags. result keeps its previous value, and resultValid is low in the cycle after.
- R7: Test forms opA AND opB and clears the carry and overflow flags.
- R8: Reset (rstN low) clears flags, result and resultValid. When flagEn is low, the flags and result hold whatever the operand and operation inputs do. The flagsQ bit order is {C,S,Z,V} from bit 3 down to bit 0.
- R9: Condition codes 0..7 take the branch on Z=1, Z=0, C=1, C=0, S=0, S=1, V=1 and V=0 respectively.
- R10: Codes 8..13 give the unsigned relations after A-B: higher (C=1 and Z=0), higher-or-equal (C=1), lower (C=0), lower-or-equal (C=0 or Z=1), equal (Z=1) and not equal (Z=0).
- R11: Codes 14..17 give the signed relations after A-B: greater (S^V=0 and Z=0), greater-or-equal (S^V=0), less (S^V=1) and less-or-equal (S^V=1 or Z=1).
- R12: Codes 18..31 never take the branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| opSel | input | 2 | Operation: 00 add, 01 subtract, 10 compare, 11 test |
| flagEn | input | 1 | Load flags (and result for add/subtract) at this edge |
| condCode | input | 5 | Branch condition index |
| result | output | W | Registered result of the last add or subtract |
| resultValid | output | 1 | High for the cycle after a result was written |
| flagsQ | output | 4 | Stored flags {C,S,Z,V} |
| takeBranch | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench goes after the overflow boundaries 0x7F+1 and 0x80-1, where a design that took V from the carry out alone would miss the signed wrap. It also covers 0xFF+1 and 0x80+0x80, where the zero flag and the carry must both be set at once. Compares in both operand orders are swept through every relational code and checked against the true unsigned and signed relations of the operands, so a swapped borrow sense or a signed test built from S alone shows up as a wrong branch. Compare and test are checked for leaving the result untouched, and idle cycles with changing inputs are checked for a drifting flag register.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_TST = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
    logic useLogic;
    logic writeRes;
    logic loadFlags;
  } aluStrobe_t;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  localparam int FLAG_C = 3;
  localparam int FLAG_S = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 0;

  // condition code indices
  localparam int CC_Z_SET   = 0;
  localparam int CC_Z_CLR   = 1;
  localparam int CC_C_SET   = 2;
  localparam int CC_C_CLR   = 3;
  localparam int CC_PLUS    = 4;
  localparam int CC_MINUS   = 5;
  localparam int CC_V_SET   = 6;
  localparam int CC_V_CLR   = 7;
  localparam int CC_U_HI    = 8;
  localparam int CC_U_HE    = 9;
  localparam int CC_U_LO    = 10;
  localparam int CC_U_LE    = 11;
  localparam int CC_EQ      = 12;
  localparam int CC_NE      = 13;
  localparam int CC_S_GT    = 14;
  localparam int CC_S_GE    = 15;
  localparam int CC_S_LT    = 16;
  localparam int CC_S_LE    = 17;
  localparam int CC_USED    = 18;

endpackage

// File: rtl/alu_cond_ctrl.sv
module alu_cond_ctrl
  import alu_cond_pkg::*;
(
  input  logic [1:0] opSel,
  input  logic       flagEn,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe           = '0;
    strobe.loadFlags = flagEn;
    case (aluOp_e'(opSel))
      OP_ADD: begin
        strobe.writeRes = 1'b1;
      end
      OP_SUB: begin
        strobe.invertB  = 1'b1;
        strobe.carryIn  = 1'b1;
        strobe.writeRes = 1'b1;
      end
      OP_CMP: begin
        strobe.invertB  = 1'b1;
        strobe.carryIn  = 1'b1;
      end
      default: begin
        strobe.useLogic = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_cond_datapath.sv
module alu_cond_datapath
  import alu_cond_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] resultQ,
  output logic         validQ,
  output flags_t       flagsQ
);

  localparam int LOW_W = W - 1;

  logic [W-1:0] bOperand;
  logic [W-1:0] lowSum;     // LOW_W sum bits plus carry into top bit
  logic [1:0]   topSum;     // top bit plus carry out
  logic         carryTop;   // carry into bit W-1
  logic         carryOut;   // carry out of bit W-1
  logic [W-1:0] addRes;
  logic [W-1:0] andRes;
  logic [W-1:0] nextRes;
  flags_t       nextFlags;

  assign bOperand = strobe.invertB ? ~opB : opB;

  // adder split at the top bit so both top carries are visible
  assign lowSum   = {1'b0, opA[LOW_W-1:0]} + {1'b0, bOperand[LOW_W-1:0]}
                  + {{LOW_W{1'b0}}, strobe.carryIn};
  assign carryTop = lowSum[LOW_W];
  assign topSum   = {1'b0, opA[W-1]} + {1'b0, bOperand[W-1]} + {1'b0, carryTop};
  assign carryOut = topSum[1];
  assign addRes   = {topSum[0], lowSum[LOW_W-1:0]};
  assign andRes   = opA & opB;
  assign nextRes  = strobe.useLogic ? andRes : addRes;

  always_comb begin
    nextFlags.c = strobe.useLogic ? 1'b0 : carryOut;
    nextFlags.s = nextRes[W-1];
    nextFlags.z = (nextRes == '0);
    nextFlags.v = strobe.useLogic ? 1'b0 : (carryTop ^ carryOut);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ  <= '0;
      resultQ <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobe.loadFlags & strobe.writeRes;
      if (strobe.loadFlags) begin
        flagsQ <= nextFlags;
      end
      if (strobe.loadFlags && strobe.writeRes) begin
        resultQ <= nextRes;
      end
    end
  end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_cond_pkg::*;
#(
  parameter int COND_W = 5
) (
  input  flags_t            flags,
  input  logic [COND_W-1:0] condCode,
  output logic              take
);

  localparam int NUM_CODES = 1 << COND_W;

  logic [NUM_CODES-1:0] condVec;
  logic                 signedLess;

  assign signedLess = flags.s ^ flags.v;

  always_comb begin
    condVec           = '0;
    condVec[CC_Z_SET] = flags.z;
    condVec[CC_Z_CLR] = ~flags.z;
    condVec[CC_C_SET] = flags.c;
    condVec[CC_C_CLR] = ~flags.c;
    condVec[CC_PLUS]  = ~flags.s;
    condVec[CC_MINUS] = flags.s;
    condVec[CC_V_SET] = flags.v;
    condVec[CC_V_CLR] = ~flags.v;
    condVec[CC_U_HI]  = flags.c & ~flags.z;
    condVec[CC_U_HE]  = flags.c;
    condVec[CC_U_LO]  = ~flags.c;
    condVec[CC_U_LE]  = ~flags.c | flags.z;
    condVec[CC_EQ]    = flags.z;
    condVec[CC_NE]    = ~flags.z;
    condVec[CC_S_GT]  = ~signedLess & ~flags.z;
    condVec[CC_S_GE]  = ~signedLess;
    condVec[CC_S_LT]  = signedLess;
    condVec[CC_S_LE]  = signedLess | flags.z;
  end

  assign take = condVec[condCode];

endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_cond_pkg::*;
#(
  parameter int W      = 8,
  parameter int COND_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [1:0]        opSel,
  input  logic              flagEn,
  input  logic [COND_W-1:0] condCode,
  output logic [W-1:0]      result,
  output logic              resultValid,
  output logic [3:0]        flagsQ,
  output logic              takeBranch
);

  aluStrobe_t strobe;
  flags_t     flagsInt;

  alu_cond_ctrl u_ctrl (
    .opSel  (opSel),
    .flagEn (flagEn),
    .strobe (strobe)
  );

  alu_cond_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .resultQ (result),
    .validQ  (resultValid),
    .flagsQ  (flagsInt)
  );

  alu_cond_eval #(.COND_W(COND_W)) u_eval (
    .flags    (flagsInt),
    .condCode (condCode),
    .take     (takeBranch)
  );

  assign flagsQ = flagsInt;

endmodule

// File: rtl/alu_cond_chk.sv
module alu_cond_chk
  import alu_cond_pkg::*;
#(
  parameter int W      = 8,
  parameter int COND_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [W-1:0]      opA,
  input logic [W-1:0]      opB,
  input logic [1:0]        opSel,
  input logic              flagEn,
  input logic [COND_W-1:0] condCode,
  input logic [W-1:0]      result,
  input logic              resultValid,
  input logic [3:0]        flagsQ,
  input logic              takeBranch
);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !flagEn |=> $stable(flagsQ)); // R8

  AST_RESULT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!flagEn || opSel == OP_CMP || opSel == OP_TST) |=> ($stable(result) && !resultValid)); // R6

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (flagsQ[FLAG_Z] == (result == '0))); // R3

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (flagsQ[FLAG_S] == result[W-1])); // R2

  AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && opSel == OP_TST) |=> (!flagsQ[FLAG_C] && !flagsQ[FLAG_V])); // R7

  AST_EQUAL_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    (flagEn && opSel == OP_CMP && opA == opB) |=> (flagsQ[FLAG_Z] && flagsQ[FLAG_C] && !flagsQ[FLAG_V])); // R5

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(condCode) >= CC_USED) |-> !takeBranch); // R12

endmodule

bind alu_cond_unit alu_cond_chk #(.W(W), .COND_W(COND_W)) u_chk (.*);

// File: tb/sim_alu_cond_unit.sv
`timescale 1ns/1ps
module sim_alu_cond_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] opA, opB;
  logic [1:0] opSel;
  logic       flagEn;
  logic [4:0] condCode;
  logic [7:0] result;
  logic       resultValid;
  logic [3:0] flagsQ;
  logic       takeBranch;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  done       = 0;

  always #2.5 clk = ~clk;

  alu_cond_unit u0 (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .flagEn(flagEn), .condCode(condCode), .result(result),
    .resultValid(resultValid), .flagsQ(flagsQ), .takeBranch(takeBranch)
  );

  // {opSel, opA, opB}
  localparam logic [17:0] VECS [12] = '{
    {2'b00, 8'h7F, 8'h01},
    {2'b00, 8'hFF, 8'h01},
    {2'b00, 8'h80, 8'h80},
    {2'b00, 8'h12, 8'h34},
    {2'b01, 8'h05, 8'h07},
    {2'b01, 8'h80, 8'h01},
    {2'b01, 8'h40, 8'h40},
    {2'b10, 8'h03, 8'hF0},
    {2'b10, 8'hF0, 8'h03},
    {2'b10, 8'h81, 8'h81},
    {2'b11, 8'hF0, 8'h0F},
    {2'b11, 8'h80, 8'hC0}
  };

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // model: returns {c,s,z,v} in bits 11..8 and the value in bits 7..0
  function automatic int model(input int op, input int a, input int b);
    int r, c, v, wide, sw;
    if (op == 0) begin
      wide = a + b; sw = sx(a) + sx(b);
      c = (wide > 255) ? 1 : 0; v = (sw > 127 || sw < -128) ? 1 : 0;
      r = wide & 255;
    end else if (op == 3) begin
      r = a & b; c = 0; v = 0;
    end else begin
      wide = a - b; sw = sx(a) - sx(b);
      c = (a >= b) ? 1 : 0; v = (sw > 127 || sw < -128) ? 1 : 0;
      r = wide & 255;
    end
    return (c << 11) | (((r >> 7) & 1) << 10) | (((r == 0) ? 1 : 0) << 9) | (v << 8) | r;
  endfunction

  function automatic int expTake(input int code, input int fl, input int op, input int a, input int b);
    int c, s, z, v;
    bit rel;
    c = (fl >> 3) & 1; s = (fl >> 2) & 1; z = (fl >> 1) & 1; v = fl & 1;
    rel = (op == 1 || op == 2);
    case (code)
      0: return z;        1: return 1 - z;
      2: return c;        3: return 1 - c;
      4: return 1 - s;    5: return s;
      6: return v;        7: return 1 - v;
      8:  return rel ? int'(a > b)  : (c & (1 - z));
      9:  return rel ? int'(a >= b) : c;
      10: return rel ? int'(a < b)  : 1 - c;
      11: return rel ? int'(a <= b) : ((1 - c) | z);
      12: return rel ? int'(a == b) : z;
      13: return rel ? int'(a != b) : 1 - z;
      14: return rel ? int'(sx(a) > sx(b))  : ((1 - (s ^ v)) & (1 - z));
      15: return rel ? int'(sx(a) >= sx(b)) : 1 - (s ^ v);
      16: return rel ? int'(sx(a) < sx(b))  : (s ^ v);
      17: return rel ? int'(sx(a) <= sx(b)) : ((s ^ v) | z);
      default: return 0;
    endcase
  endfunction

  function automatic string codeReq(input int code);
    if (code < 8) return "R9";
    if (code < 14) return "R10";
    if (code < 18) return "R11";
    return "R12";
  endfunction

  task automatic sweepCodes(input int fl, input int op, input int a, input int b);
    for (int k = 0; k < 32; k++) begin
      condCode = 5'(k);
      #0.2;
      check(codeReq(k), int'(takeBranch), expTake(k, fl, op, a, b));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    int lastRes = 0;
    rstN = 1'b0; opA = '0; opB = '0; opSel = '0; flagEn = 1'b0; condCode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, R8
    check("R8", int'(flagsQ), 0);
    check("R8", int'(result), 0);
    check("R8", int'(resultValid), 0);
    condCode = 5'd1; #0.2;
    check("R9", int'(takeBranch), 1);
    rstN = 1'b1;

    for (int i = 0; i < 12; i++) begin
      int op, a, b, m, fl, r;
      op = int'(VECS[i][17:16]); a = int'(VECS[i][15:8]); b = int'(VECS[i][7:0]);
      m = model(op, a, b); fl = (m >> 8) & 15; r = m & 255;
      @(negedge clk);
      opSel = 2'(op); opA = 8'(a); opB = 8'(b); flagEn = 1'b1;
      @(negedge clk);
      flagEn = 1'b0;
      check((op == 0) ? "R1" : (op == 3) ? "R7" : "R5", int'(flagsQ[3]), (fl >> 3) & 1);
      check("R2", int'(flagsQ[2]), (fl >> 2) & 1);
      check("R3", int'(flagsQ[1]), (fl >> 1) & 1);
      check((op == 3) ? "R7" : "R4", int'(flagsQ[0]), fl & 1);
      if (op < 2) begin
        check((op == 0) ? "R1" : "R5", int'(result), r);
        check("R1", int'(resultValid), 1);
        lastRes = r;
      end else begin
        check("R6", int'(result), lastRes);
        check("R6", int'(resultValid), 0);
      end
      sweepCodes(fl, op, a, b);
      @(negedge clk);
      check("R1", int'(resultValid), 0);
      check("R8", int'(flagsQ), fl);
    end

    // idle cycles with moving inputs: nothing may change
    begin
      int held;
      held = int'(flagsQ);
      @(negedge clk);
      opSel = 2'b00; opA = 8'hFF; opB = 8'h01;
      repeat (2) @(negedge clk);
      opSel = 2'b01; opA = 8'h00; opB = 8'h01;
      repeat (2) @(negedge clk);
      check("R8", int'(flagsQ), held);
      check("R8", int'(result), lastRes);
      check("R8", int'(resultValid), 0);
    end

    // reset in mid-run clears state again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8", int'(flagsQ), 0);
    check("R8", int'(result), 0);
    rstN = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checkCount, failCount);
    $finish;
  end

endmodule